// File: doc/BRIEF.md
# Serial Management Slave with Strap Defaults

This block is the management end of a 10/100 Ethernet PHY. A station manager sends serial read and write frames on a dedicated input line, and every bit is clocked by the management clock. The slave answers on a separate output line. An output-enable strobe marks the cycles in which that line carries read data, so an external tristate buffer or a capture register can use it. The slave responds only when the PHY address field of a frame matches its own effective address. That address is the address pins plus a port offset, wrapped to five bits, which lets several identical ports share one bus.

Inside, a small register file holds four configuration bits: autonegotiation enable, 100 Mb/s select, full duplex and automatic crossover. While reset is held, these bits take the defaults decoded from a 3-bit strap code. Four status inputs are registered and can be read live. Any change on them sets a sticky flag, and the active-low interrupt stays asserted until a read of the flag register has returned and cleared every flag. The serial protocol has no back-pressure and no valid/ready handshake: one bit moves per clock, and the manager sets the pace of the frames. The block runs on the management clock, and its reset is synchronous to that clock.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: The input line is sampled on each rising clock edge. A frame is taken only after at least PRE_MIN (default 32) consecutive ones, followed by start bits 0 then 1, a 2-bit opcode (10 = read, 01 = write), a 5-bit PHY address, a 5-bit register address, 2 turnaround bits and 16 data bits, all MSB first. A frame with a shorter preamble, or with opcode 00 or 11, gets no response.
- R2: On a read, mdo and mdoen change only just after a rising edge. The rising edge that samples the first turnaround bit raises mdoen with mdo = 0. The next 16 edges put data bits 15 down to 0 on mdo. The edge after that drops mdoen, so mdoen stays high for exactly 17 clock periods.
- R3: The effective address is (pin_addr + port_offs) mod 32, with pin_addr zero-extended.
- R4: A frame whose PHY address differs from the effective address never raises mdoen, and a write in such a frame changes no register.
- R5: Register 0 holds the configuration in bits [3] autonegotiation enable, [2] 100 Mb/s select, [1] full duplex and [0] automatic crossover. A write loads data bits [3:0], and bits [15:4] always read 0.
- R6: While rst_n is low, register 0 is loaded from strap_code, giving bits [3:0]: 000→1111, 001→1110, 010→0000, 011→0010, 100→0100, 101→0110, 110→0001, 111→0100. For codes 000 and 001, the speed and duplex bits that are free read as 100 full.
- R7: Register 1 returns the registered status inputs in bits [3:0] and 0 above. Writes to it are ignored.
- R8: A change on any status input sets its sticky flag in register 2. Within two clock edges, irq_n goes low and stays low while any flag is set, and a read of register 1 leaves it low.
- R9: A read of register 2 returns the flags in bits [3:0] and clears them at the edge where the read data is captured. A change arriving at that same edge is kept. irq_n returns high when no flag is left.
- R10: Register addresses 3 to 31 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; captures the strap code |
| mdi | input | 1 | Serial frame input from the station manager |
| mdo | output | 1 | Serial read data output |
| mdoen | output | 1 | High while mdo carries the turnaround zero and read data |
| irq_n | output | 1 | Active-low interrupt, low while any change flag is set |
| pin_addr | input | 4 | Address pins of this port |
| port_offs | input | 5 | Port offset added to the address pins |
| strap_code | input | 3 | Strap code that sets the configuration defaults at reset |
| stat_in | input | 4 | Watched status inputs |

## Verification
The bench goes after the bit-exact read window: the turnaround zero, MSB-first data and a strobe exactly 17 periods long. A design off by one edge would shift every data bit or leave a period with no strobe. Address wrap is tested with an offset that overflows five bits, so a design that does not truncate the sum would never answer. All eight strap codes are covered, and so are mismatched writes, frames with a short preamble and frames with an illegal opcode; a wrong decode or a missing filter shows up as a wrong read-back value. The interrupt is driven by a status bit that toggles twice before it is read: a design that compares against the old value instead of holding a sticky flag would clear early, and a design that clears on a read of the live register would also fail.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  localparam logic [4:0] RA_CFG  = 5'd0;
  localparam logic [4:0] RA_LIVE = 5'd1;
  localparam logic [4:0] RA_CHG  = 5'd2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_HDR,
    S_TA1,
    S_TA2,
    S_DATA
  } fsm_t;

  typedef struct packed {
    logic an_en;
    logic spd100;
    logic fdx;
    logic xover_auto;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  function automatic cfg_t strap_to_cfg(input logic [2:0] code);
    cfg_t c;
    case (code)
      3'b000:  c = '{an_en: 1'b1, spd100: 1'b1, fdx: 1'b1, xover_auto: 1'b1};
      3'b001:  c = '{an_en: 1'b1, spd100: 1'b1, fdx: 1'b1, xover_auto: 1'b0};
      3'b010:  c = '{an_en: 1'b0, spd100: 1'b0, fdx: 1'b0, xover_auto: 1'b0};
      3'b011:  c = '{an_en: 1'b0, spd100: 1'b0, fdx: 1'b1, xover_auto: 1'b0};
      3'b100:  c = '{an_en: 1'b0, spd100: 1'b1, fdx: 1'b0, xover_auto: 1'b0};
      3'b101:  c = '{an_en: 1'b0, spd100: 1'b1, fdx: 1'b1, xover_auto: 1'b0};
      3'b110:  c = '{an_en: 1'b0, spd100: 1'b0, fdx: 1'b0, xover_auto: 1'b1};
      default: c = '{an_en: 1'b0, spd100: 1'b1, fdx: 1'b0, xover_auto: 1'b0};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/mdio_addr_calc.sv
module mdio_addr_calc #(
  parameter int PIN_W = 4,
  parameter int AW    = 5
) (
  input  logic [PIN_W-1:0] pin_addr,
  input  logic [AW-1:0]    port_offs,
  output logic [AW-1:0]    eff_addr
);

  logic [AW-1:0] pin_ext;
  logic [AW:0]   sum;

  generate
    if (PIN_W < AW) begin : g_pad
      assign pin_ext = {{(AW-PIN_W){1'b0}}, pin_addr};
    end else begin : g_cut
      assign pin_ext = pin_addr[AW-1:0];
    end
  endgenerate

  // carry out is dropped: the address space wraps
  assign sum      = {1'b0, pin_ext} + {1'b0, port_offs};
  assign eff_addr = sum[AW-1:0];

  logic unused_carry;
  assign unused_carry = sum[AW];

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_MIN = 32,
  parameter int DW      = 16,
  parameter int AW      = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mdi,
  input  logic [AW-1:0] eff_addr,
  input  logic [DW-1:0] rd_data,
  output logic          mdo,
  output logic          mdoen,
  output logic          rd_strobe,
  output logic          wr_strobe,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] wr_data
);

  localparam int HDR_W = 2 + 2*AW;
  localparam int CW    = $clog2(DW + 1);
  localparam int PW    = $clog2(PRE_MIN + 1);

  fsm_t             state;
  logic [PW-1:0]    pre_cnt;
  logic [CW-1:0]    bit_cnt;
  logic [HDR_W-1:0] hdr;
  logic [HDR_W-1:0] hdr_nx;
  logic [DW-1:0]    shreg;
  logic [DW-1:0]    wsh;
  logic             mdo_q;
  logic             mdoen_q;

  logic [1:0]    op;
  logic [AW-1:0] phy_f;
  logic [1:0]    op_nx;
  logic          hit;
  logic          last_data;

  assign hdr_nx    = {hdr[HDR_W-2:0], mdi};
  assign op_nx     = hdr_nx[HDR_W-1 -: 2];
  assign op        = hdr[HDR_W-1 -: 2];
  assign phy_f     = hdr[2*AW-1 -: AW];
  assign reg_addr  = hdr[AW-1:0];
  assign hit       = (phy_f == eff_addr);
  assign last_data = (bit_cnt == CW'(DW - 1));

  assign rd_strobe = (state == S_TA1) && (op == OP_RD) && hit;
  assign wr_strobe = (state == S_DATA) && last_data && (op == OP_WR) && hit;
  assign wr_data   = {wsh[DW-2:0], mdi};

  assign mdo   = mdo_q;
  assign mdoen = mdoen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      pre_cnt <= '0;
      bit_cnt <= '0;
      hdr     <= '0;
      shreg   <= '0;
      wsh     <= '0;
      mdo_q   <= 1'b0;
      mdoen_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (mdi) begin
            if (pre_cnt != PW'(PRE_MIN)) pre_cnt <= pre_cnt + 1'b1;
          end else begin
            if (pre_cnt == PW'(PRE_MIN)) state <= S_START;
            pre_cnt <= '0;
          end
        end
        S_START: begin
          state   <= mdi ? S_HDR : S_IDLE;
          bit_cnt <= '0;
        end
        S_HDR: begin
          hdr     <= hdr_nx;
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == CW'(HDR_W - 1)) begin
            bit_cnt <= '0;
            state   <= (op_nx == OP_RD || op_nx == OP_WR) ? S_TA1 : S_IDLE;
          end
        end
        S_TA1: begin
          state <= S_TA2;
          if (rd_strobe) begin
            mdoen_q <= 1'b1;
            mdo_q   <= 1'b0;
            shreg   <= rd_data;
          end
        end
        S_TA2: begin
          state   <= S_DATA;
          bit_cnt <= '0;
          if (mdoen_q) begin
            mdo_q <= shreg[DW-1];
            shreg <= {shreg[DW-2:0], 1'b0};
          end
        end
        S_DATA: begin
          wsh     <= {wsh[DW-2:0], mdi};
          bit_cnt <= bit_cnt + 1'b1;
          if (mdoen_q) begin
            if (last_data) begin
              mdoen_q <= 1'b0;
              mdo_q   <= 1'b0;
            end else begin
              mdo_q <= shreg[DW-1];
              shreg <= {shreg[DW-2:0], 1'b0};
            end
          end
          if (last_data) begin
            state   <= S_IDLE;
            bit_cnt <= '0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // strobe length counter used only by the checks below
  logic [CW:0] strb_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)       strb_cnt <= '0;
    else if (mdoen_q) strb_cnt <= strb_cnt + 1'b1;
    else              strb_cnt <= '0;
  end

  // R2: read window is exactly turnaround zero plus the data bits
  assert_strobe_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdoen_q) |-> (strb_cnt == (CW+1)'(DW + 1)));

  // R2: first driven bit is the turnaround zero
  assert_ta_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdoen_q) |-> !mdo_q);

  // R4: output only driven for frames addressed to this port
  assert_drive_own_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdoen_q) |-> (phy_f == eff_addr));

  // R1: output only driven for the read opcode
  assert_drive_read_op_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdoen_q) |-> (op == OP_RD));

endmodule

// File: rtl/mdio_chg_irq.sv
module mdio_chg_irq #(
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] stat_in,
  input  logic          clr,
  output logic [SW-1:0] stat_live,
  output logic [SW-1:0] flags,
  output logic          irq_n
);

  logic [SW-1:0] stat_prev;
  logic [SW-1:0] chg;

  assign chg       = stat_live ^ stat_prev;
  assign irq_n     = ~(|flags);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_live <= stat_in;
      stat_prev <= stat_in;
      flags     <= '0;
    end else begin
      stat_live <= stat_in;
      stat_prev <= stat_live;
      flags     <= (clr ? '0 : flags) | chg;
    end
  end

  // R8: interrupt only asserts after a detected change
  assert_irq_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(|chg));

  // R9: interrupt only releases after a read of the flags
  assert_irq_release_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> $past(clr));

endmodule

// File: rtl/mdio_cfg_regs.sv
module mdio_cfg_regs
  import mdio_mgmt_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 5,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    strap_code,
  input  logic [SW-1:0] stat_live,
  input  logic [SW-1:0] chg_flags,
  input  logic [AW-1:0] reg_addr,
  input  logic          wr_strobe,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);

  cfg_t cfg;
  logic cfg_wr;

  assign cfg_wr = wr_strobe && (reg_addr == AW'(RA_CFG));

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg <= strap_to_cfg(strap_code);
    else if (cfg_wr) cfg <= cfg_t'(wr_data[CFG_W-1:0]);
  end

  always_comb begin
    case (reg_addr)
      AW'(RA_CFG):  rd_data = {{(DW-CFG_W){1'b0}}, cfg};
      AW'(RA_LIVE): rd_data = {{(DW-SW){1'b0}}, stat_live};
      AW'(RA_CHG):  rd_data = {{(DW-SW){1'b0}}, chg_flags};
      default:      rd_data = '0;
    endcase
  end

  logic unused_wr_hi;
  assign unused_wr_hi = ^wr_data[DW-1:CFG_W];

  // R5: configuration only moves on an addressed write to it
  assert_cfg_write_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cfg) && $past(rst_n)) |-> $past(cfg_wr));

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_mgmt_pkg::*;
#(
  parameter int PIN_W   = 4,
  parameter int AW      = 5,
  parameter int DW      = 16,
  parameter int SW      = 4,
  parameter int PRE_MIN = 32
) (
  input  logic             mdc,
  input  logic             rst_n,
  input  logic             mdi,
  output logic             mdo,
  output logic             mdoen,
  output logic             irq_n,
  input  logic [PIN_W-1:0] pin_addr,
  input  logic [AW-1:0]    port_offs,
  input  logic [2:0]       strap_code,
  input  logic [SW-1:0]    stat_in
);

  logic [AW-1:0] eff_addr;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] rd_data;
  logic [DW-1:0] wr_data;
  logic          rd_strobe;
  logic          wr_strobe;
  logic [SW-1:0] stat_live;
  logic [SW-1:0] chg_flags;
  logic          chg_clr;

  assign chg_clr = rd_strobe && (reg_addr == AW'(RA_CHG));

  mdio_addr_calc #(.PIN_W(PIN_W), .AW(AW)) u_addr (
    .pin_addr  (pin_addr),
    .port_offs (port_offs),
    .eff_addr  (eff_addr)
  );

  mdio_frame_engine #(.PRE_MIN(PRE_MIN), .DW(DW), .AW(AW)) u_fsm (
    .clk       (mdc),
    .rst_n     (rst_n),
    .mdi       (mdi),
    .eff_addr  (eff_addr),
    .rd_data   (rd_data),
    .mdo       (mdo),
    .mdoen     (mdoen),
    .rd_strobe (rd_strobe),
    .wr_strobe (wr_strobe),
    .reg_addr  (reg_addr),
    .wr_data   (wr_data)
  );

  mdio_chg_irq #(.SW(SW)) u_chg (
    .clk       (mdc),
    .rst_n     (rst_n),
    .stat_in   (stat_in),
    .clr       (chg_clr),
    .stat_live (stat_live),
    .flags     (chg_flags),
    .irq_n     (irq_n)
  );

  mdio_cfg_regs #(.DW(DW), .AW(AW), .SW(SW)) u_regs (
    .clk        (mdc),
    .rst_n      (rst_n),
    .strap_code (strap_code),
    .stat_live  (stat_live),
    .chg_flags  (chg_flags),
    .reg_addr   (reg_addr),
    .wr_strobe  (wr_strobe),
    .wr_data    (wr_data),
    .rd_data    (rd_data)
  );

endmodule

// File: tb/mdio_mgmt_slave_tb.sv
module mdio_mgmt_slave_tb;

  logic       mdc = 1'b0;
  logic       rst_n = 1'b0;
  logic       mdi = 1'b1;
  logic       mdo;
  logic       mdoen;
  logic       irq_n;
  logic [3:0] pin_addr = 4'd3;
  logic [4:0] port_offs = 5'd2;
  logic [2:0] strap_code = 3'b000;
  logic [3:0] stat_in = 4'b0000;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 mdc = ~mdc;

  mdio_mgmt_slave u_dut (
    .mdc        (mdc),
    .rst_n      (rst_n),
    .mdi        (mdi),
    .mdo        (mdo),
    .mdoen      (mdoen),
    .irq_n      (irq_n),
    .pin_addr   (pin_addr),
    .port_offs  (port_offs),
    .strap_code (strap_code),
    .stat_in    (stat_in)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge mdc);
    mdi = b;
  endtask

  task automatic send_hdr(input int pre, input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra);
    for (int i = 0; i < pre; i++) send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    for (int i = 1; i >= 0; i--) send_bit(op[i]);
    for (int i = 4; i >= 0; i--) send_bit(phy[i]);
    for (int i = 4; i >= 0; i--) send_bit(ra[i]);
  endtask

  // returns data, number of strobe periods, and a timing-shape flag
  task automatic rd_frame(input int pre, input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra,
                          output logic [15:0] data, output int slen, output logic shape_ok);
    data = '0;
    slen = 0;
    shape_ok = 1'b1;
    send_hdr(pre, op, phy, ra);
    for (int k = 0; k < 19; k++) begin
      @(negedge mdc);
      if (mdoen) slen++;
      if (k == 0 && mdoen) shape_ok = 1'b0;
      if (k == 1 && mdoen && mdo) shape_ok = 1'b0;
      if (k >= 2 && k <= 17) data = {data[14:0], mdo};
      if (k == 18 && mdoen) shape_ok = 1'b0;
      mdi = 1'b1;
    end
  endtask

  task automatic wr_frame(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    send_hdr(32, 2'b01, phy, ra);
    send_bit(1'b1);
    send_bit(1'b0);
    for (int i = 15; i >= 0; i--) send_bit(d[i]);
    send_bit(1'b1);
  endtask

  task automatic rd_reg(input logic [4:0] phy, input logic [4:0] ra, output logic [15:0] data, output int slen);
    logic ok;
    rd_frame(32, 2'b10, phy, ra, data, slen, ok);
  endtask

  task automatic do_reset(input logic [2:0] code);
    @(negedge mdc);
    rst_n = 1'b0;
    strap_code = code;
    repeat (4) @(negedge mdc);
    rst_n = 1'b1;
    @(negedge mdc);
  endtask

  function automatic logic [3:0] strap_exp(input logic [2:0] c);
    case (c)
      3'b000:  return 4'b1111;
      3'b001:  return 4'b1110;
      3'b010:  return 4'b0000;
      3'b011:  return 4'b0010;
      3'b100:  return 4'b0100;
      3'b101:  return 4'b0110;
      3'b110:  return 4'b0001;
      default: return 4'b0100;
    endcase
  endfunction

  task automatic t_reset_state();
    do_reset(3'b000);
    chk("R8 reset irq_n high", {15'd0, irq_n}, 16'd1);
    chk("R2 reset mdoen low", {15'd0, mdoen}, 16'd0);
  endtask

  task automatic t_read_timing();
    logic [15:0] d;
    int sl;
    logic ok;
    rd_frame(32, 2'b10, 5'd5, 5'd0, d, sl, ok);
    chk("R2 strobe periods", 16'(sl), 16'd17);
    chk("R2 turnaround zero and window shape", {15'd0, ok}, 16'd1);
    chk("R6 strap 000 readback", d, 16'h000F);
  endtask

  task automatic t_strap_all();
    logic [15:0] d;
    int sl;
    for (int c = 0; c < 8; c++) begin
      do_reset(3'(c));
      rd_reg(5'd5, 5'd0, d, sl);
      chk($sformatf("R6 strap code %0d", c), d, {12'd0, strap_exp(3'(c))});
    end
  endtask

  task automatic t_cfg_write();
    logic [15:0] d;
    int sl;
    do_reset(3'b010);
    wr_frame(5'd5, 5'd0, 16'hFFF5);
    rd_reg(5'd5, 5'd0, d, sl);
    chk("R5 cfg write keeps only [3:0]", d, 16'h0005);
    wr_frame(5'd5, 5'd0, 16'h000A);
    rd_reg(5'd5, 5'd0, d, sl);
    chk("R5 cfg second write", d, 16'h000A);
  endtask

  task automatic t_addr_offset();
    logic [15:0] d;
    int sl;
    pin_addr = 4'd9;
    port_offs = 5'd30;
    rd_reg(5'd7, 5'd0, d, sl);
    chk("R3 wrapped address answers", 16'(sl), 16'd17);
    chk("R3 wrapped address data", d, 16'h000A);
    rd_reg(5'd9, 5'd0, d, sl);
    chk("R4 pin-only address ignored", 16'(sl), 16'd0);
    wr_frame(5'd8, 5'd0, 16'h0003);
    rd_reg(5'd7, 5'd0, d, sl);
    chk("R4 mismatched write no effect", d, 16'h000A);
    pin_addr = 4'd3;
    port_offs = 5'd2;
  endtask

  task automatic t_bad_frames();
    logic [15:0] d;
    int sl;
    logic ok;
    rd_frame(8, 2'b10, 5'd5, 5'd0, d, sl, ok);
    chk("R1 short preamble ignored", 16'(sl), 16'd0);
    rd_frame(32, 2'b11, 5'd5, 5'd0, d, sl, ok);
    chk("R1 opcode 11 ignored", 16'(sl), 16'd0);
    rd_frame(32, 2'b00, 5'd5, 5'd0, d, sl, ok);
    chk("R1 opcode 00 ignored", 16'(sl), 16'd0);
    rd_reg(5'd5, 5'd0, d, sl);
    chk("R1 good frame after bad ones", 16'(sl), 16'd17);
  endtask

  task automatic t_unmapped();
    logic [15:0] d;
    int sl;
    wr_frame(5'd5, 5'd5, 16'hFFFF);
    rd_reg(5'd5, 5'd5, d, sl);
    chk("R10 unmapped reads zero", d, 16'h0000);
    rd_reg(5'd5, 5'd0, d, sl);
    chk("R10 unmapped write left cfg", d, 16'h000A);
    wr_frame(5'd5, 5'd1, 16'h000F);
    rd_reg(5'd5, 5'd1, d, sl);
    chk("R7 live reg not writable", d, {12'd0, stat_in});
  endtask

  task automatic t_status_irq();
    logic [15:0] d;
    int sl;
    stat_in = 4'b0000;
    do_reset(3'b000);
    chk("R8 no flag after reset", {15'd0, irq_n}, 16'd1);
    stat_in = 4'b0101;
    repeat (4) @(negedge mdc);
    chk("R8 irq asserted on change", {15'd0, irq_n}, 16'd0);
    rd_reg(5'd5, 5'd1, d, sl);
    chk("R7 live status", d, 16'h0005);
    chk("R8 live read keeps irq", {15'd0, irq_n}, 16'd0);
    stat_in = 4'b0001;
    repeat (4) @(negedge mdc);
    rd_reg(5'd5, 5'd2, d, sl);
    chk("R9 sticky flags read", d, 16'h0005);
    chk("R9 irq released after read", {15'd0, irq_n}, 16'd1);
    rd_reg(5'd5, 5'd2, d, sl);
    chk("R9 flags cleared", d, 16'h0000);
  endtask

  initial begin
    repeat (1) @(negedge mdc);
    t_reset_state();
    t_read_timing();
    t_strap_all();
    t_cfg_write();
    t_addr_offset();
    t_bad_frames();
    t_unmapped();
    t_status_irq();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule